// File: doc/BRIEF.md
# Gate Driver Protection and Status Sequencer

This block is the clocked decision core of a single-channel isolated gate driver for IGBTs and power MOSFETs. A drive command arrives from an optical receiver. The block resynchronises it and maps it to an on/off request through a polarity strap. It then decides whether the gate may follow that request. The analog comparators report two conditions, and the block takes both in as single-bit flags: the transistor has come out of saturation while conducting, and the isolated supply is healthy.

The block sends one status line back to the controller. This line is asserted, meaning the open-drain transistor conducts, in three cases: while the supply is below its threshold, for a whole blocking interval after a fault, and for a short acknowledge pulse on every change of the effective command. A mode strap selects how faults act on the gate. In stop mode a fault forces the gate off and keeps it off for the blocking interval. In report mode, used for series-connected stacks, the gate keeps following the command and the fault is only signalled, so that the controller can shut down every device in a coordinated way.

Three values set the response blanking, blocking and acknowledge times, each as a count of system clock cycles. A count value N gives an interval of N+1 cycles.

Top module: `gate_guard`

## Requirements
- R1: With `invStrap` low, `cmdIn` low requests the transistor on and high requests it off. With `invStrap` high, the mapping is reversed. A change on `cmdIn` made between clock edges reaches `gateOn` on the third rising edge after the change.
- R2: After reset, `gateOn` is 0 and `statusActive` is 1 regardless of the command. This holds until `supplyOk` is sampled high. On the edge after that sample, `statusActive` falls, provided no acknowledge pulse is running.
- R3: `desatFlag` is ignored for the first `respCnt`+1 cycles after `gateOn` rises. From then on, while the gate stays on, a high sample counts as a desaturation fault.
- R4: In stop mode (`seriesMode` = 0), a desaturation fault clears `gateOn` on the same edge that samples it. `statusActive` is then 1 for exactly `blockCnt`+1 cycles.
- R5: In stop mode, the command is ignored during the blocking interval. On the edge after the interval ends, `gateOn` again equals the requested state.
- R6: In report mode (`seriesMode` = 1), a desaturation fault leaves `gateOn` following the command. `statusActive` is still 1 for `blockCnt`+1 cycles.
- R7: Once `supplyOk` is sampled low, `statusActive` is 1 from the next edge for as long as the supply is low. In stop mode the gate is forced off. In report mode the gate keeps following the command. When the supply returns, a blocking interval of `blockCnt`+1 cycles follows.
- R8: Each change of the effective command asserts `statusActive` for `ackCnt`+1 cycles. The pulse starts on the same edge at which `gateOn` would change.
- R9: A command change that arrives while an acknowledge pulse is running restarts the pulse at full width.
- R10: A count of zero for blanking, blocking or acknowledge gives an interval of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdIn | input | 1 | Asynchronous drive command from the optical receiver |
| invStrap | input | 1 | Command polarity select (0: low means on) |
| seriesMode | input | 1 | Fault reaction (0: stop gate, 1: report only) |
| desatFlag | input | 1 | Comparator flag: on-state voltage above reference |
| supplyOk | input | 1 | Supply comparator flag, hysteresis applied outside the block |
| respCnt | input | CNT_W | Response blanking count (interval = value+1 cycles) |
| blockCnt | input | CNT_W | Blocking count (interval = value+1 cycles) |
| ackCnt | input | CNT_W | Acknowledge pulse count (width = value+1 cycles) |
| gateOn | output | 1 | Gate enable to the output stage |
| statusActive | output | 1 | 1 = status transistor conducting (fault, undervoltage or acknowledge) |

## Verification
The hardest case to reach is the first cycle after the blanking window. A desaturation flag must be present while the gate has just turned on, so that the exact edge at which protection arms can be seen. The bench raises the flag before it requests turn-on and holds it there. It then counts edges from the command change through the synchroniser, the gate register and the blanking counter, and checks that the gate is still on in the last blanked cycle and off in the next one. It does this with both a nonzero blanking count and a zero one. The same held flag in report mode shows that the status line goes active while the gate stays on.

// File: rtl/gate_guard_pkg.sv
`timescale 1ns/1ps
package gate_guard_pkg;

  typedef enum logic [1:0] {
    ST_INIT  = 2'd0,
    ST_RUN   = 2'd1,
    ST_BLOCK = 2'd2,
    ST_UVLO  = 2'd3
  } ggState_e;

  // control -> datapath
  typedef struct packed {
    logic gateOn;
    logic blockLoad;
    logic blockCount;
  } ggStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic wantOn;
    logic armed;
    logic blockDone;
    logic ackBusy;
  } ggFlags_t;

endpackage

// File: rtl/gg_datapath.sv
`timescale 1ns/1ps
module gg_datapath
  import gate_guard_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdIn,
  input  logic             invStrap,
  input  logic [CNT_W-1:0] respCnt,
  input  logic [CNT_W-1:0] blockCnt,
  input  logic [CNT_W-1:0] ackCnt,
  input  ggStrobe_t        strobe,
  output ggFlags_t         flags
);

  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  // polarity applied before synchronising; the strap is static
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   wantOnS;
  logic                   wantOnD;
  logic                   cmdEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '0;
      wantOnD <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], cmdIn ~^ invStrap};
      wantOnD <= wantOnS;
    end
  end

  assign wantOnS = syncQ[SYNC_STAGES-1];
  assign cmdEdge = wantOnS ^ wantOnD;

  // acknowledge pulse timer, restarted by every edge
  logic [CNT_W-1:0] ackTmr;
  logic             ackBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackBusy <= 1'b0;
      ackTmr  <= CNT_ZERO;
    end else if (cmdEdge) begin
      ackBusy <= 1'b1;
      ackTmr  <= ackCnt;
    end else if (ackBusy) begin
      if (ackTmr == CNT_ZERO) ackBusy <= 1'b0;
      else                    ackTmr  <= ackTmr - CNT_ONE;
    end
  end

  // response blanking after gate turn-on
  logic [CNT_W-1:0] respElapsed;
  logic             armedReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respElapsed <= CNT_ZERO;
      armedReg    <= 1'b0;
    end else if (!strobe.gateOn) begin
      respElapsed <= CNT_ZERO;
      armedReg    <= 1'b0;
    end else if (!armedReg) begin
      if (respElapsed == respCnt) armedReg    <= 1'b1;
      else                        respElapsed <= respElapsed + CNT_ONE;
    end
  end

  // blocking interval timer
  logic [CNT_W-1:0] blkTmr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blkTmr <= CNT_ZERO;
    end else if (strobe.blockLoad) begin
      blkTmr <= blockCnt;
    end else if (strobe.blockCount && blkTmr != CNT_ZERO) begin
      blkTmr <= blkTmr - CNT_ONE;
    end
  end

  assign flags.wantOn    = wantOnS;
  assign flags.armed     = armedReg && strobe.gateOn;
  assign flags.blockDone = (blkTmr == CNT_ZERO);
  assign flags.ackBusy   = ackBusy;

  // R8: an effective command edge always opens a status pulse
  p_edge_opens_ack_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmdEdge |=> ackBusy);

  // R9: a pulse with time left keeps running
  p_ack_continues_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ackBusy && ackTmr != CNT_ZERO) |=> ackBusy);

  // R3: the cycle in which the gate turns on is always blanked
  p_blank_on_turnon_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.gateOn) |-> !flags.armed);

endmodule

// File: rtl/gg_control.sv
`timescale 1ns/1ps
module gg_control
  import gate_guard_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      seriesMode,
  input  logic      desatFlag,
  input  logic      supplyOk,
  input  ggFlags_t  flags,
  output ggStrobe_t strobe,
  output logic      statusActive
);

  ggState_e state, stateNext;
  logic     gateOnQ, gateNext;
  logic     blockLoad;
  logic     desatHit;

  assign desatHit = flags.armed && desatFlag;

  always_comb begin
    stateNext = state;
    blockLoad = 1'b0;
    gateNext  = 1'b0;
    unique case (state)
      ST_INIT: begin
        if (supplyOk) stateNext = ST_RUN;
      end
      ST_RUN: begin
        gateNext = flags.wantOn && (seriesMode || (supplyOk && !desatHit));
        if (!supplyOk) begin
          stateNext = ST_UVLO;
        end else if (desatHit) begin
          stateNext = ST_BLOCK;
          blockLoad = 1'b1;
        end
      end
      ST_BLOCK: begin
        gateNext = seriesMode && flags.wantOn;
        if (!supplyOk)            stateNext = ST_UVLO;
        else if (flags.blockDone) stateNext = ST_RUN;
      end
      ST_UVLO: begin
        gateNext = seriesMode && flags.wantOn;
        if (supplyOk) begin
          stateNext = ST_BLOCK;
          blockLoad = 1'b1;
        end
      end
      default: stateNext = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_INIT;
      gateOnQ <= 1'b0;
    end else begin
      state   <= stateNext;
      gateOnQ <= gateNext;
    end
  end

  assign strobe.gateOn     = gateOnQ;
  assign strobe.blockLoad  = blockLoad;
  assign strobe.blockCount = (state == ST_BLOCK);
  assign statusActive      = (state != ST_RUN) || flags.ackBusy;

  // R2: gate held off until the supply has been seen good
  p_init_gate_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_INIT) |-> !gateOnQ);

  // R7: low supply is reported from the next edge
  p_uv_reported_r7: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> statusActive);

  // R4: stop mode drops the gate on the faulting edge
  p_desat_drops_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && !seriesMode && desatHit) |=> !gateOnQ);

  // R5: stop mode keeps the gate off throughout blocking
  p_block_gate_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BLOCK && !seriesMode && $past(!seriesMode)) |-> !gateOnQ);

  // R6: report mode always follows the command once started
  p_series_follows_r6: assert property (@(posedge clk) disable iff (!rstN)
    (seriesMode && state != ST_INIT) |=> (gateOnQ == $past(flags.wantOn)));

endmodule

// File: rtl/gate_guard.sv
`timescale 1ns/1ps
module gate_guard
  import gate_guard_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdIn,
  input  logic             invStrap,
  input  logic             seriesMode,
  input  logic             desatFlag,
  input  logic             supplyOk,
  input  logic [CNT_W-1:0] respCnt,
  input  logic [CNT_W-1:0] blockCnt,
  input  logic [CNT_W-1:0] ackCnt,
  output logic             gateOn,
  output logic             statusActive
);

  ggStrobe_t strobe;
  ggFlags_t  flags;

  gg_datapath #(
    .CNT_W      (CNT_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .cmdIn   (cmdIn),
    .invStrap(invStrap),
    .respCnt (respCnt),
    .blockCnt(blockCnt),
    .ackCnt  (ackCnt),
    .strobe  (strobe),
    .flags   (flags)
  );

  gg_control i_control (
    .clk         (clk),
    .rstN        (rstN),
    .seriesMode  (seriesMode),
    .desatFlag   (desatFlag),
    .supplyOk    (supplyOk),
    .flags       (flags),
    .strobe      (strobe),
    .statusActive(statusActive)
  );

  assign gateOn = strobe.gateOn;

endmodule

// File: tb/test_gate_guard.sv
`timescale 1ns/1ps
module test_gate_guard;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cmdIn = 1'b1;
  logic             invStrap = 1'b0;
  logic             seriesMode = 1'b0;
  logic             desatFlag = 1'b0;
  logic             supplyOk = 1'b0;
  logic [CNT_W-1:0] respCnt = '0;
  logic [CNT_W-1:0] blockCnt = '0;
  logic [CNT_W-1:0] ackCnt = '0;
  logic             gateOn;
  logic             statusActive;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  gate_guard #(.CNT_W(CNT_W)) i_gate_guard (
    .clk(clk), .rstN(rstN), .cmdIn(cmdIn), .invStrap(invStrap),
    .seriesMode(seriesMode), .desatFlag(desatFlag), .supplyOk(supplyOk),
    .respCnt(respCnt), .blockCnt(blockCnt), .ackCnt(ackCnt),
    .gateOn(gateOn), .statusActive(statusActive)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // request on/off in terms of the effective command
  task automatic setCmd(input logic on);
    cmdIn = invStrap ? on : ~on;
  endtask

  task automatic doReset(input logic inv, input logic ser, input int r, input int b, input int a);
    rstN = 1'b0;
    invStrap = inv; seriesMode = ser;
    respCnt = CNT_W'(r); blockCnt = CNT_W'(b); ackCnt = CNT_W'(a);
    desatFlag = 1'b0; supplyOk = 1'b0;
    setCmd(1'b0);
    cyc(3);
    rstN = 1'b1;
    cyc(2);
    supplyOk = 1'b1;
    cyc(2);
  endtask

  task automatic t_reset_r2;
    rstN = 1'b0; invStrap = 1'b0; seriesMode = 1'b0; supplyOk = 1'b0;
    desatFlag = 1'b0; ackCnt = '0; blockCnt = '0; respCnt = '0;
    setCmd(1'b0);
    cyc(3);
    rstN = 1'b1;
    setCmd(1'b1);
    cyc(6);
    chk("R2", "gate held off before supply good", gateOn, 1'b0);
    chk("R2", "status active before supply good", statusActive, 1'b1);
    supplyOk = 1'b1;
    cyc(1);
    chk("R2", "status released after supply good", statusActive, 1'b0);
    chk("R2", "gate still off on release edge", gateOn, 1'b0);
    cyc(1);
    chk("R2", "gate follows command after release", gateOn, 1'b1);
  endtask

  task automatic t_polarity_r1;
    doReset(1'b0, 1'b0, 0, 0, 3);
    setCmd(1'b1);
    chk("R1", "non-inverted cmdIn low", cmdIn, 1'b0);
    cyc(2);
    chk("R1", "gate not yet on after two edges", gateOn, 1'b0);
    chk("R8", "no pulse before edge reaches logic", statusActive, 1'b0);
    cyc(1);
    chk("R1", "gate on at third edge", gateOn, 1'b1);
    chk("R8", "pulse starts with gate change", statusActive, 1'b1);
    cyc(3);
    chk("R8", "pulse last cycle (ackCnt+1)", statusActive, 1'b1);
    cyc(1);
    chk("R8", "pulse over", statusActive, 1'b0);
    setCmd(1'b0);
    cyc(3);
    chk("R1", "gate off after cmdIn high", gateOn, 1'b0);
    chk("R8", "falling command edge also pulses", statusActive, 1'b1);
    doReset(1'b1, 1'b0, 0, 0, 0);
    setCmd(1'b1);
    chk("R1", "inverted cmdIn high", cmdIn, 1'b1);
    cyc(3);
    chk("R1", "inverted: high cmdIn turns gate on", gateOn, 1'b1);
    setCmd(1'b0);
    cyc(3);
    chk("R1", "inverted: low cmdIn turns gate off", gateOn, 1'b0);
  endtask

  task automatic t_restart_r9;
    doReset(1'b0, 1'b0, 0, 0, 3);
    setCmd(1'b1);
    cyc(2);
    setCmd(1'b0);
    cyc(1);
    chk("R9", "first pulse running", statusActive, 1'b1);
    cyc(2);
    chk("R1", "gate off after second change", gateOn, 1'b0);
    cyc(3);
    chk("R9", "pulse extended by restart", statusActive, 1'b1);
    cyc(1);
    chk("R9", "restarted pulse ends", statusActive, 1'b0);
  endtask

  task automatic t_desat_stop_r4;
    doReset(1'b0, 1'b0, 4, 5, 0);
    desatFlag = 1'b1;
    setCmd(1'b1);
    cyc(3);
    chk("R10", "one-cycle pulse present", statusActive, 1'b1);
    cyc(1);
    chk("R10", "one-cycle pulse gone", statusActive, 1'b0);
    cyc(4);
    chk("R3", "gate on in last blanked cycle", gateOn, 1'b1);
    chk("R3", "no fault reported while blanked", statusActive, 1'b0);
    cyc(1);
    chk("R4", "gate dropped on fault", gateOn, 1'b0);
    chk("R4", "fault reported", statusActive, 1'b1);
    desatFlag = 1'b0;
    cyc(5);
    chk("R4", "status held to end of blocking", statusActive, 1'b1);
    chk("R5", "command ignored during blocking", gateOn, 1'b0);
    cyc(1);
    chk("R4", "status released after blockCnt+1", statusActive, 1'b0);
    chk("R5", "gate still off on release edge", gateOn, 1'b0);
    cyc(1);
    chk("R5", "gate follows command after blocking", gateOn, 1'b1);
  endtask

  task automatic t_zero_counts_r10;
    doReset(1'b0, 1'b0, 0, 0, 0);
    desatFlag = 1'b1;
    setCmd(1'b1);
    cyc(4);
    chk("R10", "one blanked cycle with zero count", gateOn, 1'b1);
    cyc(1);
    chk("R10", "fault right after one blanked cycle", gateOn, 1'b0);
    chk("R10", "zero blocking: status on", statusActive, 1'b1);
    desatFlag = 1'b0;
    cyc(1);
    chk("R10", "zero blocking lasts one cycle", statusActive, 1'b0);
    cyc(1);
    chk("R5", "gate back after one-cycle block", gateOn, 1'b1);
  endtask

  task automatic t_series_r6;
    doReset(1'b0, 1'b1, 2, 3, 0);
    desatFlag = 1'b1;
    setCmd(1'b1);
    cyc(6);
    chk("R6", "no report while blanked", statusActive, 1'b0);
    cyc(1);
    chk("R6", "fault reported", statusActive, 1'b1);
    chk("R6", "gate kept on", gateOn, 1'b1);
    desatFlag = 1'b0;
    cyc(3);
    chk("R6", "report lasts blockCnt+1", statusActive, 1'b1);
    cyc(1);
    chk("R6", "report ends", statusActive, 1'b0);
    chk("R6", "gate still on", gateOn, 1'b1);
    supplyOk = 1'b0;
    cyc(1);
    chk("R7", "series: supply loss reported", statusActive, 1'b1);
    chk("R7", "series: gate kept on", gateOn, 1'b1);
    supplyOk = 1'b1;
    cyc(4);
    chk("R7", "series: blocking after supply return", statusActive, 1'b1);
    cyc(1);
    chk("R7", "series: report ends", statusActive, 1'b0);
  endtask

  task automatic t_supply_r7;
    doReset(1'b0, 1'b0, 0, 2, 0);
    setCmd(1'b1);
    cyc(5);
    chk("R7", "gate on with good supply", gateOn, 1'b1);
    supplyOk = 1'b0;
    cyc(1);
    chk("R7", "gate off on supply loss", gateOn, 1'b0);
    chk("R7", "status on supply loss", statusActive, 1'b1);
    cyc(4);
    chk("R7", "status held during undervoltage", statusActive, 1'b1);
    supplyOk = 1'b1;
    cyc(3);
    chk("R7", "blocking after supply return", statusActive, 1'b1);
    chk("R7", "gate off during blocking", gateOn, 1'b0);
    cyc(1);
    chk("R7", "status released", statusActive, 1'b0);
    cyc(1);
    chk("R7", "gate follows again", gateOn, 1'b1);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset_r2();
    t_polarity_r1();
    t_restart_r9();
    t_desat_stop_r4();
    t_zero_counts_r10();
    t_series_r6();
    t_supply_r7();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule